// File: doc/BRIEF.md
# Macro-to-Micro-op Sequencer

The block takes one already-decoded macro-instruction at a time and turns it into an ordered train of simple micro-ops. It emits one micro-op per clock over a valid/ready handshake. Plain register arithmetic, compares and branches map to a single micro-op. Arithmetic with a memory operand, push, call and return expand into fixed multi-step sequences. These sequences pass intermediate values through a dedicated temporary register.

The controller is a two-state machine. `S_IDLE` means no macro is held and the input is ready. `S_EMIT` means a macro is latched and its micro-ops are being presented. The transition `S_IDLE -> S_EMIT` fires on an input handshake. `S_EMIT -> S_EMIT` covers two cases: a stall, and a hand-off of a micro-op that is not the last one. `S_EMIT -> S_IDLE` fires on the hand-off of the micro-op flagged end-of-sequence. A step counter selects which micro-op of the sequence is shown.

With default parameters, the stack pointer is register 14, the temporary is register 31 and the stack slot is 4 bytes. Immediates are 32-bit two's complement, so -4 is 0xFFFFFFFC. Unused micro-op fields are zero. A store uses address = src_a + imm and data = src_b. A load uses address = src_a + imm.

Top module: `uop_cracker`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: Class 0 (register ALU) gives one micro-op {kind 1 ALU, dst rd, a rd, b rs}. Class 3 (compare) gives one micro-op {kind 4, a rd, b rs}. Class 4 (branch) gives one micro-op {kind 5, imm disp}.
- R3: Class 1 (ALU with a memory source) gives two micro-ops. First, LOAD {kind 2, dst 31, a base, imm disp}. Then ALU {kind 1, dst rd, a rd, b 31}.
- R4: Class 2 (ALU with a memory destination) gives three micro-ops. First, LOAD {2, dst 31, a base, imm disp}. Second, ALU {1, dst 31, a 31, b rs}. Third, STORE {kind 3, a base, b 31, imm disp}, which writes back to the same address.
- R5: Class 5 (push) gives two micro-ops. First, STORE {3, a 14, b rs, imm -4}. Then the stack adjust {kind 9, dst 14, a 14, imm -4}.
- R6: Class 6 (call) gives four micro-ops, in this order:
  - get-PC {kind 8, dst 31, imm next-PC};
  - STORE {3, a 14, b 31, imm -4};
  - stack adjust {9, dst 14, a 14, imm -4};
  - jump {kind 6, imm disp}.
- R7: Class 7 (return) gives three micro-ops, in this order:
  - stack adjust {9, dst 14, a 14, imm +4};
  - LOAD {2, dst 31, a 14, imm -4};
  - register jump {kind 7, a 31}.
- R8: out_eos is 1 only on the last micro-op of a sequence. While a sequence is in flight, in_ready is 0 and in_valid is ignored. After the last micro-op is handed off, out_valid drops and in_ready returns to 1.
- R9: While out_valid is 1 and out_ready is 0, every micro-op output holds its value and the sequence does not advance.
- R10: Classes 8 to 15 each give a single micro-op {kind 15 illegal, all other fields 0}, flagged end-of-sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Macro-op offered |
| in_ready | output | 1 | Macro-op can be taken |
| in_cls | input | 4 | Macro-op class |
| in_rd | input | 5 | Destination / first source register |
| in_rs | input | 5 | Second source register |
| in_base | input | 5 | Memory base register |
| in_disp | input | 32 | Displacement or branch/call target |
| in_npc | input | 32 | Address of the following instruction |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Micro-op taken this cycle |
| out_kind | output | 4 | Micro-op kind |
| out_dst | output | 5 | Destination register |
| out_src_a | output | 5 | First source / address base |
| out_src_b | output | 5 | Second source / store data |
| out_imm | output | 32 | Immediate |
| out_eos | output | 1 | Last micro-op of the sequence |

## Verification
The hardest case to reach from the ports combines three conditions. The downstream stalls on the final micro-op of a sequence. At the same time a new macro is already being offered. The release must still happen exactly once, with no early acceptance. The stimulus reaches this case by choosing out_ready at random every cycle with a high stall rate. It also raises in_valid with scrambled fields during emission. Every class is run directly, and a long seeded random stream follows.

// File: rtl/uop_pkg.sv
package uop_pkg;
    localparam int REG_W  = 5;
    localparam int IMM_W  = 32;
    localparam int CLS_W  = 4;
    localparam int KIND_W = 4;

    typedef enum logic [CLS_W-1:0] {
        MC_ALU_RR   = 4'd0,
        MC_ALU_MSRC = 4'd1,
        MC_ALU_MDST = 4'd2,
        MC_CMP      = 4'd3,
        MC_BR       = 4'd4,
        MC_PUSH     = 4'd5,
        MC_CALL     = 4'd6,
        MC_RET      = 4'd7
    } mclass_e;

    typedef enum logic [KIND_W-1:0] {
        U_NOP   = 4'd0,
        U_ALU   = 4'd1,
        U_LOAD  = 4'd2,
        U_STORE = 4'd3,
        U_CMP   = 4'd4,
        U_BR    = 4'd5,
        U_JMP   = 4'd6,
        U_JR    = 4'd7,
        U_LPC   = 4'd8,
        U_SPADJ = 4'd9,
        U_ILL   = 4'd15
    } ukind_e;

    typedef struct packed {
        ukind_e           kind;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [IMM_W-1:0] imm;
    } uop_t;
endpackage

// File: rtl/uop_step_ctr.sv
module uop_step_ctr #(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [STEP_W-1:0] step
);
    always_ff @(posedge clk) begin
        if (!rst_n)   step <= '0;
        else if (clr) step <= '0;
        else if (adv) step <= step + STEP_W'(1);
    end
endmodule

// File: rtl/uop_seq_table.sv
module uop_seq_table
    import uop_pkg::*;
#(
    parameter int STEP_W = 2,
    parameter int SP_IDX = 14,
    parameter int TMP_IDX = 31,
    parameter int SLOT = 4
) (
    input  logic [CLS_W-1:0]  cls,
    input  logic [STEP_W-1:0] step,
    input  logic [REG_W-1:0]  rd,
    input  logic [REG_W-1:0]  rs,
    input  logic [REG_W-1:0]  base,
    input  logic [IMM_W-1:0]  disp,
    input  logic [IMM_W-1:0]  npc,
    output uop_t              uop,
    output logic              last
);
    localparam logic [REG_W-1:0] SP  = REG_W'(SP_IDX);
    localparam logic [REG_W-1:0] TMP = REG_W'(TMP_IDX);
    localparam logic [IMM_W-1:0] DN  = IMM_W'(0) - IMM_W'(SLOT);
    localparam logic [IMM_W-1:0] UP  = IMM_W'(SLOT);

    always_comb begin
        uop  = '0;
        last = 1'b1;
        case (cls)
            MC_ALU_RR: begin
                uop.kind = U_ALU; uop.dst = rd; uop.src_a = rd; uop.src_b = rs;
            end
            MC_CMP: begin
                uop.kind = U_CMP; uop.src_a = rd; uop.src_b = rs;
            end
            MC_BR: begin
                uop.kind = U_BR; uop.imm = disp;
            end
            MC_ALU_MSRC: begin
                last = (step == STEP_W'(1));
                if (step == '0) begin
                    uop.kind = U_LOAD; uop.dst = TMP; uop.src_a = base; uop.imm = disp;
                end else begin
                    uop.kind = U_ALU; uop.dst = rd; uop.src_a = rd; uop.src_b = TMP;
                end
            end
            MC_ALU_MDST: begin
                last = (step == STEP_W'(2));
                if (step == '0) begin
                    uop.kind = U_LOAD; uop.dst = TMP; uop.src_a = base; uop.imm = disp;
                end else if (step == STEP_W'(1)) begin
                    uop.kind = U_ALU; uop.dst = TMP; uop.src_a = TMP; uop.src_b = rs;
                end else begin
                    uop.kind = U_STORE; uop.src_a = base; uop.src_b = TMP; uop.imm = disp;
                end
            end
            MC_PUSH: begin
                last = (step == STEP_W'(1));
                if (step == '0) begin
                    uop.kind = U_STORE; uop.src_a = SP; uop.src_b = rs; uop.imm = DN;
                end else begin
                    uop.kind = U_SPADJ; uop.dst = SP; uop.src_a = SP; uop.imm = DN;
                end
            end
            MC_CALL: begin
                last = (step == STEP_W'(3));
                if (step == '0) begin
                    uop.kind = U_LPC; uop.dst = TMP; uop.imm = npc;
                end else if (step == STEP_W'(1)) begin
                    uop.kind = U_STORE; uop.src_a = SP; uop.src_b = TMP; uop.imm = DN;
                end else if (step == STEP_W'(2)) begin
                    uop.kind = U_SPADJ; uop.dst = SP; uop.src_a = SP; uop.imm = DN;
                end else begin
                    uop.kind = U_JMP; uop.imm = disp;
                end
            end
            MC_RET: begin
                last = (step == STEP_W'(2));
                if (step == '0) begin
                    uop.kind = U_SPADJ; uop.dst = SP; uop.src_a = SP; uop.imm = UP;
                end else if (step == STEP_W'(1)) begin
                    uop.kind = U_LOAD; uop.dst = TMP; uop.src_a = SP; uop.imm = DN;
                end else begin
                    uop.kind = U_JR; uop.src_a = TMP;
                end
            end
            default: begin
                uop.kind = U_ILL;
            end
        endcase
    end
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
    import uop_pkg::*;
#(
    parameter int SP_IDX  = 14,
    parameter int TMP_IDX = 31,
    parameter int SLOT    = 4,
    parameter int MAX_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [CLS_W-1:0] in_cls,
    input  logic [REG_W-1:0] in_rd,
    input  logic [REG_W-1:0] in_rs,
    input  logic [REG_W-1:0] in_base,
    input  logic [IMM_W-1:0] in_disp,
    input  logic [IMM_W-1:0] in_npc,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [KIND_W-1:0] out_kind,
    output logic [REG_W-1:0] out_dst,
    output logic [REG_W-1:0] out_src_a,
    output logic [REG_W-1:0] out_src_b,
    output logic [IMM_W-1:0] out_imm,
    output logic             out_eos
);
    localparam int STEP_W = $clog2(MAX_LEN);

    typedef enum logic {S_IDLE, S_EMIT} state_e;
    state_e state, state_nx;

    logic [CLS_W-1:0]  h_cls;
    logic [REG_W-1:0]  h_rd, h_rs, h_base;
    logic [IMM_W-1:0]  h_disp, h_npc;
    logic [STEP_W-1:0] step;
    uop_t              cur;
    logic              cur_last;
    logic              accept, handoff;

    assign accept  = in_valid && in_ready;
    assign handoff = out_valid && out_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (accept) state_nx = S_EMIT;
            S_EMIT: if (handoff && cur_last) state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_cls <= '0; h_rd <= '0; h_rs <= '0; h_base <= '0;
            h_disp <= '0; h_npc <= '0;
        end else if (accept) begin
            h_cls <= in_cls; h_rd <= in_rd; h_rs <= in_rs; h_base <= in_base;
            h_disp <= in_disp; h_npc <= in_npc;
        end
    end

    uop_step_ctr #(.STEP_W(STEP_W)) u_step (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (accept),
        .adv  (handoff && !cur_last),
        .step (step)
    );

    uop_seq_table #(
        .STEP_W(STEP_W), .SP_IDX(SP_IDX), .TMP_IDX(TMP_IDX), .SLOT(SLOT)
    ) u_table (
        .cls (h_cls), .step(step), .rd(h_rd), .rs(h_rs), .base(h_base),
        .disp(h_disp), .npc(h_npc), .uop(cur), .last(cur_last)
    );

    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state)
            S_IDLE: in_ready  = 1'b1;
            S_EMIT: out_valid = 1'b1;
        endcase
        out_kind  = cur.kind;
        out_dst   = cur.dst;
        out_src_a = cur.src_a;
        out_src_b = cur.src_b;
        out_imm   = cur.imm;
        out_eos   = cur_last;
    end

    p_hold_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid &&
        $stable({out_kind, out_dst, out_src_a, out_src_b, out_imm, out_eos}));

    p_busy_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_release_after_eos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_eos |=> !out_valid && in_ready);

    p_accept_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);

    p_illegal_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_kind == 4'd15 |-> out_eos);

    p_step_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && !out_eos |=> step != '0);
endmodule

// File: tb/tb_uop_cracker.sv
`timescale 1ns/1ps
module tb_uop_cracker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_cls = '0;
    logic [4:0]  in_rd = '0, in_rs = '0, in_base = '0;
    logic [31:0] in_disp = '0, in_npc = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [3:0]  out_kind;
    logic [4:0]  out_dst, out_src_a, out_src_b;
    logic [31:0] out_imm;
    logic        out_eos;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    localparam logic [31:0] M4 = 32'hFFFF_FFFC;
    localparam logic [31:0] P4 = 32'h0000_0004;

    always #2 clk = ~clk;

    uop_cracker dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_cls(in_cls), .in_rd(in_rd), .in_rs(in_rs), .in_base(in_base),
        .in_disp(in_disp), .in_npc(in_npc), .out_valid(out_valid),
        .out_ready(out_ready), .out_kind(out_kind), .out_dst(out_dst),
        .out_src_a(out_src_a), .out_src_b(out_src_b), .out_imm(out_imm),
        .out_eos(out_eos)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input logic [3:0] c);
        case (c)
            4'd1, 4'd5: return 2;
            4'd2, 4'd7: return 3;
            4'd6:       return 4;
            default:    return 1;
        endcase
    endfunction

    function automatic logic [50:0] mk(input logic [3:0] k, input logic [4:0] d,
                                       input logic [4:0] a, input logic [4:0] b,
                                       input logic [31:0] imm);
        return {k, d, a, b, imm};
    endfunction

    function automatic logic [50:0] exp_uop(input logic [3:0] c, input int i,
            input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] bs,
            input logic [31:0] disp, input logic [31:0] npc);
        case (c)
            4'd0: return mk(4'd1, rd, rd, rs, 32'd0);
            4'd1: return (i == 0) ? mk(4'd2, 5'd31, bs, 5'd0, disp)
                                  : mk(4'd1, rd, rd, 5'd31, 32'd0);
            4'd2: return (i == 0) ? mk(4'd2, 5'd31, bs, 5'd0, disp) :
                         (i == 1) ? mk(4'd1, 5'd31, 5'd31, rs, 32'd0)
                                  : mk(4'd3, 5'd0, bs, 5'd31, disp);
            4'd3: return mk(4'd4, 5'd0, rd, rs, 32'd0);
            4'd4: return mk(4'd5, 5'd0, 5'd0, 5'd0, disp);
            4'd5: return (i == 0) ? mk(4'd3, 5'd0, 5'd14, rs, M4)
                                  : mk(4'd9, 5'd14, 5'd14, 5'd0, M4);
            4'd6: return (i == 0) ? mk(4'd8, 5'd31, 5'd0, 5'd0, npc) :
                         (i == 1) ? mk(4'd3, 5'd0, 5'd14, 5'd31, M4) :
                         (i == 2) ? mk(4'd9, 5'd14, 5'd14, 5'd0, M4)
                                  : mk(4'd6, 5'd0, 5'd0, 5'd0, disp);
            4'd7: return (i == 0) ? mk(4'd9, 5'd14, 5'd14, 5'd0, P4) :
                         (i == 1) ? mk(4'd2, 5'd31, 5'd14, 5'd0, M4)
                                  : mk(4'd7, 5'd0, 5'd31, 5'd0, 32'd0);
            default: return mk(4'd15, 5'd0, 5'd0, 5'd0, 32'd0);
        endcase
    endfunction

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'd0, 4'd3, 4'd4: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic scramble();
        in_cls = 4'($urandom); in_rd = 5'($urandom); in_rs = 5'($urandom);
        in_base = 5'($urandom); in_disp = $urandom; in_npc = $urandom;
    endtask

    // Entered just after a falling edge, with the block idle.
    task automatic run_macro(input logic [3:0] c, input int stall_pct, input bit noise);
        logic [4:0]  rd, rs, bs;
        logic [31:0] disp, npc;
        logic [50:0] act, exp;
        int len, idx, guard;
        bit rdy, prev_stall;
        rd = 5'($urandom_range(0, 13)); rs = 5'($urandom_range(0, 13));
        bs = 5'($urandom_range(0, 13)); disp = $urandom; npc = $urandom;
        chk(in_ready == 1'b1, "R8 idle before macro", 64'(in_ready), 64'd1);
        in_valid = 1'b1; in_cls = c; in_rd = rd; in_rs = rs; in_base = bs;
        in_disp = disp; in_npc = npc;
        @(negedge clk);
        in_valid = 1'b0;
        scramble();
        len = exp_len(c); idx = 0; guard = 0; prev_stall = 1'b0;
        while (idx < len && guard < 400) begin
            act = {out_kind, out_dst, out_src_a, out_src_b, out_imm};
            exp = exp_uop(c, idx, rd, rs, bs, disp, npc);
            chk(out_valid == 1'b1, "R8 valid during sequence", 64'(out_valid), 64'd1);
            chk(in_ready == 1'b0, "R8 not ready while busy", 64'(in_ready), 64'd0);
            chk(act == exp, prev_stall ? "R9 held micro-op" : req_of(c), 64'(act), 64'(exp));
            chk(out_eos == (idx == len - 1), "R8 end marker", 64'(out_eos), 64'(idx == len - 1));
            rdy = ($urandom_range(0, 99) >= stall_pct);
            out_ready = rdy;
            in_valid = noise && ($urandom_range(0, 1) == 1);
            scramble();
            @(negedge clk);
            if (rdy) idx++;
            prev_stall = !rdy;
            guard++;
        end
        out_ready = 1'b0;
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R8 released after end", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R8 ready after end", 64'(in_ready), 64'd1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog expired after %0d cycles", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd371));
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 reset valid", 64'(out_valid), 64'd0);
        chk(in_ready == 1'b1, "R1 reset ready", 64'(in_ready), 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after reset", 64'(out_valid), 64'd0);
        for (int c = 0; c < 16; c++) run_macro(4'(c), 0, 0);
        for (int c = 0; c < 16; c++) run_macro(4'(c), 75, 1);
        for (int n = 0; n < 400; n++) run_macro(4'($urandom_range(0, 15)), 35, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule